// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is a two-wire serial (I2C) target that gives an external controller read and write access to a bank of 256 byte-wide configuration registers. The bus lines are brought into the system clock domain through a synchroniser and a glitch filter. The block then recognises START, repeated START and STOP conditions and compares the first byte of each transfer with its 7-bit device address. One bit of that address comes from a strap input. The target acknowledges by pulling the data line low through an open-drain enable. It never drives the line high.

A write transfer carries a sub-address byte followed by any number of data bytes. A read transfer first sets the sub-address with a write, then issues a repeated START and the address with the read bit set. In both directions the internal pointer advances after every data byte and wraps from FFh to 00h. All register contents are presented as one flat parallel bus for the rest of the chip. The three polarity bits held at index E1h also appear on dedicated pins.

The system clock must run at least 16 times faster than the serial clock. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset every register reads 00h on the parallel bus and the data-line enable is low (line released).
- R2: The 7-bit device address is 42h when the strap is 0 and 43h when the strap is 1. A matching address byte is acknowledged by pulling the data line low during the ninth clock.
- R3: An address byte that does not match is not acknowledged (line released during the ninth clock). The rest of that transfer is ignored, so no register changes.
- R4: A write transfer (address with R/W=0, sub-address, data) stores the data byte at the sub-address and acknowledges every byte.
- R5: Consecutive data bytes in one write transfer go to consecutive register indices.
- R6: After a sub-address write and a repeated START with R/W=1, the target returns the registers from the sub-address upward, MSB first, one byte per acknowledged slot.
- R7: When the controller does not acknowledge a read byte, the target releases the data line and drives no further bits until the next START.
- R8: The register pointer wraps from FFh to 00h on both burst writes and burst reads.
- R9: A STOP or START in any state returns the target to its initial receive state. A data byte cut short by STOP is not stored.
- R10: The clock-edge, horizontal-sync and vertical-sync polarity outputs equal bits 0, 1 and 2 of the register at index E1h.
- R11: Register i appears on bits [8*i+7 : 8*i] of the parallel bus.
- R12: A pulse on the serial clock that is shorter than the filter length is ignored and does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Strap that selects the device address (0: 42h, 1: 43h) |
| sda_oe_o | output | 1 | High pulls the data line low; low releases it |
| reg_bus_o | output | 2048 | All registers, register i at bits [8*i+7:8*i] |
| ck_pol_o | output | 1 | Clock-edge polarity, bit 0 of register E1h |
| hs_pol_o | output | 1 | Horizontal-sync polarity, bit 1 of register E1h |
| vs_pol_o | output | 1 | Vertical-sync polarity, bit 2 of register E1h |

## Verification
The hardest case to reach from the pins is the turn of direction inside one transfer. A sub-address is written, a repeated START follows, and the target must switch from sampling the line to driving the first read bit on the falling edge that ends the address acknowledge. The bench reaches it with a full repeated-START read sequence. Each returned bit is sampled in the middle of the high phase of the serial clock, and the read ends with a controller NACK to show that the line is released. Two more cases need exact bus timing and are driven bit by bit. One cuts a byte after four bits with a STOP. The other injects a one-cycle clock pulse inside every low phase of a data byte.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } link_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   all_hi;
  logic                   all_lo;

  assign all_hi = &hist_q;
  assign all_lo = ~|hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (all_hi)      level_o <= 1'b1;
      else if (all_lo) level_o <= 1'b0;
    end
  end

  // R12: filtered level only moves when the whole window agrees
  a_r12_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_hi && !all_lo) |=> $stable(level_o));
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel_i,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe_o
);
  link_state_e       state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] ptr;
  logic              rw;
  logic              ack_seen;
  logic [6:0]        my_addr;
  logic              byte_done;
  logic              quiet;

  assign my_addr   = {DEV_ADDR[6:1], addr_sel_i};
  assign byte_done = scl_fall && (bit_cnt == 4'd8);
  assign quiet     = !start_det && !stop_det;

  assign rd_addr = ptr;
  assign wr_addr = ptr;
  assign wr_data = shreg;
  assign wr_en   = (state == ST_WDATA) && byte_done && quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      ack_seen <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == my_addr) begin
                rw       <= shreg[0];
                sda_oe_o <= 1'b1;
                state    <= ST_ADDR_ACK;
              end else begin
                state    <= ST_IDLE;
              end
            end else if (state == ST_SUB) begin
              ptr      <= shreg;
              sda_oe_o <= 1'b1;
              state    <= ST_SUB_ACK;
            end else begin
              ptr      <= ptr + 8'd1;
              sda_oe_o <= 1'b1;
              state    <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw) begin
              tx       <= rd_data;
              sda_oe_o <= ~rd_data[7];
              state    <= ST_RDATA;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_oe_o <= 1'b0;
            state    <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe_o <= 1'b0;
              ptr      <= ptr + 8'd1;
              state    <= ST_RDATA_ACK;
            end else begin
              tx       <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe_o <= ~tx[6];
              bit_cnt  <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) ack_seen <= ~sda_f;
          if (scl_fall) begin
            if (ack_seen) begin
              tx       <= rd_data;
              sda_oe_o <= ~rd_data[7];
              bit_cnt  <= '0;
              state    <= ST_RDATA;
            end else begin
              state    <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9: bus conditions force the sequencer back to its entry states
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe_o));
  a_r9_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state == ST_ADDR && bit_cnt == 4'd0));
  // R3: an idle target never holds the data line
  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe_o);
  // R8: pointer wraps after a write at the top index
  a_r8_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == 8'hFF) |=> (ptr == 8'h00));
  // R7: controller NACK ends the read with the line released
  a_r7_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RDATA_ACK && scl_fall && !ack_seen && quiet)
      |=> (state == ST_IDLE && !sda_oe_o));
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned NREG = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [BYTE_W-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [BYTE_W-1:0]      rd_addr,
  output logic [BYTE_W-1:0]      rd_data,
  output logic [NREG*BYTE_W-1:0] bus_o
);
  logic [BYTE_W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  assign rd_data = regs[rd_addr];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign bus_o[g*BYTE_W +: BYTE_W] = regs[g];
  end

  // R4: a write strobe lands its byte at the addressed index
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (regs[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h42,
  parameter logic [7:0]  POL_IDX     = 8'hE1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl_i,
  input  logic         sda_i,
  input  logic         addr_sel_i,
  output logic         sda_oe_o,
  output logic [2047:0] reg_bus_o,
  output logic         ck_pol_o,
  output logic         hs_pol_o,
  output logic         vs_pol_o
);
  localparam int unsigned NREG    = 1 << BYTE_W;
  localparam int unsigned POL_LSB = int'(POL_IDX) * BYTE_W;

  logic [1:0]        raw_lines;
  logic [1:0]        filt_lines;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_pin_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (raw_lines[g]),
      .level_o(filt_lines[g])
    );
  end

  i2c_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (filt_lines[0]),
    .sda_f    (filt_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_sel_i(addr_sel_i),
    .sda_f     (filt_lines[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe_o  (sda_oe_o)
  );

  i2c_reg_bank #(.NREG(NREG)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .bus_o  (reg_bus_o)
  );

  // R10: polarity pins taken from the register at POL_IDX
  assign ck_pol_o = reg_bus_o[POL_LSB + 0];
  assign hs_pol_o = reg_bus_o[POL_LSB + 1];
  assign vs_pol_o = reg_bus_o[POL_LSB + 2];
endmodule

// File: tb/i2c_cfg_target_tb_top.sv
`timescale 1ns/1ps
module i2c_cfg_target_tb_top;
  localparam int Q = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl_m = 1'b1;
  logic         sda_m = 1'b1;
  logic         addr_sel = 1'b0;
  logic         sda_oe;
  logic [2047:0] reg_bus;
  logic         ck_pol, hs_pol, vs_pol;
  logic         sda_line;
  int           n_chk = 0;
  int           n_fail = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_cfg_target dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .addr_sel_i(addr_sel),
    .sda_oe_o  (sda_oe),
    .reg_bus_o (reg_bus),
    .ck_pol_o  (ck_pol),
    .hs_pol_o  (hs_pol),
    .vs_pol_o  (vs_pol)
  );

  function automatic logic [7:0] reg_at(input int idx);
    return reg_bus[idx*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
    wait_q();
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    sda_m = b;
    wait_q();
    if (glitch) begin
      scl_m = 1'b1;
      @(negedge clk);
      scl_m = 1'b0;
    end
    wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1;
    wait_q(); wait_q();
    scl_m = 1'b1; wait_q();
    b = sda_line;
    wait_q();
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
    get_bit(b);
    acked = !b;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(give_ack ? 1'b0 : 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    chk(reg_bus == '0, "R1 registers clear", 32'(reg_at(0)), 32'h0);
    chk(!sda_oe, "R1 line released", 32'(sda_oe), 32'h0);
  endtask

  task automatic t_single_write();
    bit a;
    bus_start();
    send_byte(8'h84, 0, a); chk(a, "R2 address 42h ack", 32'(a), 32'h1);
    send_byte(8'h10, 0, a); chk(a, "R4 sub ack", 32'(a), 32'h1);
    send_byte(8'hA5, 0, a); chk(a, "R4 data ack", 32'(a), 32'h1);
    bus_stop();
    chk(reg_at(8'h10) == 8'hA5, "R4 stored", 32'(reg_at(8'h10)), 32'hA5);
    chk(reg_bus[16*8 +: 8] == 8'hA5, "R11 bus slice", 32'(reg_bus[16*8 +: 8]), 32'hA5);
  endtask

  task automatic t_burst_write();
    bit a;
    bit all_ack = 1;
    bus_start();
    send_byte(8'h84, 0, a); all_ack &= a;
    send_byte(8'h20, 0, a); all_ack &= a;
    send_byte(8'h11, 0, a); all_ack &= a;
    send_byte(8'h22, 0, a); all_ack &= a;
    send_byte(8'h33, 0, a); all_ack &= a;
    bus_stop();
    chk(all_ack, "R4 burst acks", 32'(all_ack), 32'h1);
    chk(reg_at(8'h20) == 8'h11, "R5 idx20", 32'(reg_at(8'h20)), 32'h11);
    chk(reg_at(8'h21) == 8'h22, "R5 idx21", 32'(reg_at(8'h21)), 32'h22);
    chk(reg_at(8'h22) == 8'h33, "R5 idx22", 32'(reg_at(8'h22)), 32'h33);
    chk(reg_at(8'h23) == 8'h00, "R5 idx23 untouched", 32'(reg_at(8'h23)), 32'h0);
  endtask

  task automatic t_read();
    bit a;
    logic [7:0] v;
    bus_start();
    send_byte(8'h84, 0, a);
    send_byte(8'h20, 0, a);
    bus_start();
    send_byte(8'h85, 0, a); chk(a, "R6 read address ack", 32'(a), 32'h1);
    recv_byte(1, v); chk(v == 8'h11, "R6 byte0", 32'(v), 32'h11);
    recv_byte(1, v); chk(v == 8'h22, "R6 byte1", 32'(v), 32'h22);
    recv_byte(0, v); chk(v == 8'h33, "R6 byte2", 32'(v), 32'h33);
    wait_q();
    chk(!sda_oe, "R7 released after nack", 32'(sda_oe), 32'h0);
    get_bit(v[0]);
    chk(v[0] == 1'b1, "R7 no further drive", 32'(v[0]), 32'h1);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    bit a;
    bus_start();
    send_byte(8'h86, 0, a); chk(!a, "R3 address 43h nack on strap 0", 32'(a), 32'h0);
    send_byte(8'h50, 0, a); chk(!a, "R3 sub ignored", 32'(a), 32'h0);
    send_byte(8'h77, 0, a);
    bus_stop();
    chk(reg_at(8'h50) == 8'h00, "R3 no write", 32'(reg_at(8'h50)), 32'h0);
  endtask

  task automatic t_strap_one();
    bit a;
    addr_sel = 1'b1;
    wait_q();
    bus_start();
    send_byte(8'h86, 0, a); chk(a, "R2 address 43h ack on strap 1", 32'(a), 32'h1);
    send_byte(8'h51, 0, a);
    send_byte(8'h3C, 0, a);
    bus_stop();
    chk(reg_at(8'h51) == 8'h3C, "R2 strap 1 write", 32'(reg_at(8'h51)), 32'h3C);
    bus_start();
    send_byte(8'h84, 0, a); chk(!a, "R3 address 42h nack on strap 1", 32'(a), 32'h0);
    bus_stop();
    addr_sel = 1'b0;
    wait_q();
  endtask

  task automatic t_wrap();
    bit a;
    logic [7:0] v;
    bus_start();
    send_byte(8'h84, 0, a);
    send_byte(8'hFF, 0, a);
    send_byte(8'hAA, 0, a);
    send_byte(8'hBB, 0, a);
    bus_stop();
    chk(reg_at(8'hFF) == 8'hAA, "R8 write top", 32'(reg_at(8'hFF)), 32'hAA);
    chk(reg_at(8'h00) == 8'hBB, "R8 write wrapped", 32'(reg_at(8'h00)), 32'hBB);
    bus_start();
    send_byte(8'h84, 0, a);
    send_byte(8'hFF, 0, a);
    bus_start();
    send_byte(8'h85, 0, a);
    recv_byte(1, v); chk(v == 8'hAA, "R8 read top", 32'(v), 32'hAA);
    recv_byte(0, v); chk(v == 8'hBB, "R8 read wrapped", 32'(v), 32'hBB);
    bus_stop();
  endtask

  task automatic t_abort();
    bit a;
    bus_start();
    send_byte(8'h84, 0, a);
    send_byte(8'h30, 0, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1, 0);
    bus_stop();
    chk(reg_at(8'h30) == 8'h00, "R9 partial byte dropped", 32'(reg_at(8'h30)), 32'h0);
    chk(!sda_oe, "R9 idle after stop", 32'(sda_oe), 32'h0);
    bus_start();
    send_byte(8'h84, 0, a); chk(a, "R9 recovers", 32'(a), 32'h1);
    send_byte(8'h30, 0, a);
    send_byte(8'h5A, 0, a);
    bus_stop();
    chk(reg_at(8'h30) == 8'h5A, "R9 write after abort", 32'(reg_at(8'h30)), 32'h5A);
  endtask

  task automatic t_polarity();
    bit a;
    bus_start();
    send_byte(8'h84, 0, a);
    send_byte(8'hE1, 0, a);
    send_byte(8'h05, 0, a);
    bus_stop();
    chk({vs_pol, hs_pol, ck_pol} == 3'b101, "R10 pol 05h", 32'({vs_pol, hs_pol, ck_pol}), 32'h5);
    bus_start();
    send_byte(8'h84, 0, a);
    send_byte(8'hE1, 0, a);
    send_byte(8'h02, 0, a);
    bus_stop();
    chk({vs_pol, hs_pol, ck_pol} == 3'b010, "R10 pol 02h", 32'({vs_pol, hs_pol, ck_pol}), 32'h2);
  endtask

  task automatic t_glitch();
    bit a;
    bus_start();
    send_byte(8'h84, 0, a);
    send_byte(8'h40, 0, a);
    send_byte(8'h96, 1, a); chk(a, "R12 glitched byte ack", 32'(a), 32'h1);
    bus_stop();
    chk(reg_at(8'h40) == 8'h96, "R12 glitch ignored", 32'(reg_at(8'h40)), 32'h96);
    chk(reg_at(8'h41) == 8'h00, "R12 no extra byte", 32'(reg_at(8'h41)), 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_write();
    t_burst_write();
    t_read();
    t_wrong_addr();
    t_strap_one();
    t_wrap();
    t_abort();
    t_polarity();
    t_glitch();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule